// File: doc/BRIEF.md
# Obstacle-Aware Mesh Router

This block is one node of a two-dimensional on-chip packet mesh in which regions of the mesh can be switched off while the chip runs. A module that is placed over an area takes the routers underneath it as logic, and the routers next to that area then see those neighbours as inactive. The node has four mesh ports, one toward each compass neighbour, and one local port for the client attached to it. Each neighbour reports a single activation bit. The node learns its own grid position from two static coordinate inputs.

Each input port holds one single-word packet. Every cycle, the node decides from its own state alone where each held packet should go. When the neighbours on the path are alive, it uses plain dimension-ordered routing: X first, then Y. When the path is blocked, the packet is turned along the edge of the dead region and marked with a stamp bit. The stamp stops the next node from sending the packet straight back. When the blocked direction opens again at the corner of the region, the stamp is cleared and the packet resumes toward its destination. Several inputs can want the same output. A round-robin arbiter on each output picks which one is served.

Top module: `mesh_router`

## Requirements
- R1: After reset, all five `out_valid` bits are 0 and all five `in_ready` bits are 1.
- R2: A packet whose destination equals (`my_x`, `my_y`) leaves on the local port (index 4) with the stamp bit cleared.
- R3: Port and activation indices are 0 = north (Y+1), 1 = east (X+1), 2 = south (Y-1), 3 = west (X-1), 4 = local. An unstamped packet with destination X not equal to `my_x` goes east if the destination X is larger and west otherwise. If the X coordinates are equal, it goes north if the destination Y is larger and south otherwise. The stamp stays 0.
- R4: If the required horizontal neighbour is inactive, an unstamped packet goes north when destination Y >= `my_y` and south otherwise, and leaves with the stamp set.
- R5: If the X coordinates are equal and the required vertical neighbour is inactive, an unstamped packet steps east when east is active and west otherwise, and leaves with the stamp set.
- R6: A stamped packet that arrived on the north or south port, with destination X not equal to `my_x`, leaves toward its destination column with the stamp cleared if that neighbour is active. Otherwise it keeps travelling in its current vertical direction with the stamp still set, even when the destination lies behind it.
- R7: A stamped packet that arrived on the east or west port, with destination Y not equal to `my_y`, leaves toward its destination row with the stamp cleared if that neighbour is active. Otherwise it keeps travelling in its current horizontal direction with the stamp still set.
- R8: No packet is presented on a mesh output whose neighbour is inactive. A packet whose chosen output is inactive waits in its input slot, and it is routed again when the activation inputs change.
- R9: The stamp bit of a packet entering on the local port is ignored, and the packet is routed as if it were unstamped.
- R10: Each input slot holds one packet. `in_ready` is 0 while the slot is occupied. The packet and its output stay unchanged until the output's `out_ready` is 1.
- R11: When several inputs want the same output, the search starts at the index after the last input that was served on that output, wrapping from 4 to 0. After reset, the search starts at index 0.
- R12: The packet layout is bits [31:28] destination X, bits [27:24] destination Y, bit [23] stamp, and bits [22:0] payload. Only the stamp bit may differ between the input word and the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 4 | Static X coordinate of this node |
| my_y | input | 4 | Static Y coordinate of this node |
| nbr_alive | input | 4 | Neighbour activation, one bit per mesh direction (1 = active) |
| in_valid | input | 5 | Packet offered on each input port |
| in_ready | output | 5 | Input slot free, per port |
| in_data | input | 160 | Five 32-bit input words, port k at bits [32k+31:32k] |
| out_valid | output | 5 | Packet presented on each output port |
| out_ready | input | 5 | Receiver accepts, per output port |
| out_data | output | 160 | Five 32-bit output words, port k at bits [32k+31:32k] |

## Verification
The bench aims at the places where the stamp changes the route. In one case, a stamped packet moving north has its destination to the south. A node that ignored the stamp would send it back south, and the two nodes would bounce it forever. In another, the corner where a blocked direction opens again must clear the stamp; a node that missed this would leave packets circling the region. A stamped packet injected locally must be routed as unstamped, because a node that read a travel direction from the local port would send it the wrong way. The bench also sends packets toward dead neighbours, holds outputs with back-pressure, and makes four inputs contend for one output. It watches for a leaked packet, a lost packet, or a grant order that does not rotate.

// File: rtl/mesh_router.sv
module mesh_router #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    my_x,
  input  logic [CW-1:0]    my_y,
  input  logic [3:0]       nbr_alive,
  input  logic [4:0]       in_valid,
  output logic [4:0]       in_ready,
  input  logic [5*DW-1:0]  in_data,
  output logic [4:0]       out_valid,
  input  logic [4:0]       out_ready,
  output logic [5*DW-1:0]  out_data
);
  localparam int NP = 5;
  localparam int SB = DW - 1 - 2*CW;
  localparam logic [2:0] PN = 3'd0, PE = 3'd1, PS = 3'd2, PW = 3'd3, PL = 3'd4;

  logic [DW-1:0]  slot [NP];
  logic [NP-1:0]  full, okgo, take, nstamp;
  logic [2:0]     dest [NP];
  logic [2:0]     rr   [NP];
  logic [2:0]     win  [NP];

  function automatic logic [3:0] pick(
    input logic [CW-1:0] dx, input logic [CW-1:0] dy,
    input logic [CW-1:0] mx, input logic [CW-1:0] my,
    input logic st, input logic [2:0] src, input logic [3:0] alive);
    logic [2:0] h, v, t;
    h = (dx > mx) ? PE : PW;
    v = (dy > my) ? PN : PS;
    t = {1'b0, src[1:0] ^ 2'b10};
    if (dx == mx && dy == my) return {PL, 1'b0};
    if (st && src != PL) begin
      if (!t[0]) begin
        if (dx != mx) return alive[h[1:0]] ? {h, 1'b0} : {t, 1'b1};
      end else if (dy != my) begin
        return alive[v[1:0]] ? {v, 1'b0} : {t, 1'b1};
      end
    end
    if (dx != mx) return alive[h[1:0]] ? {h, 1'b0} : {((dy >= my) ? PN : PS), 1'b1};
    if (alive[v[1:0]]) return {v, 1'b0};
    return {(alive[1] ? PE : PW), 1'b1};
  endfunction

  assign in_ready = ~full;

  for (genvar gi = 0; gi < NP; gi++) begin : g_in
    assign {dest[gi], nstamp[gi]} = pick(slot[gi][DW-1 -: CW], slot[gi][DW-1-CW -: CW],
                                         my_x, my_y, slot[gi][SB], 3'(gi), nbr_alive);
    assign okgo[gi] = full[gi] && (dest[gi] == PL || nbr_alive[dest[gi][1:0]]);
    assign take[gi] = okgo[gi] && out_valid[dest[gi]] && out_ready[dest[gi]]
                      && (win[dest[gi]] == 3'(gi));
  end

  for (genvar go = 0; go < NP; go++) begin : g_out
    logic       hit;
    logic [2:0] w;
    always_comb begin
      hit = 1'b0;
      w   = rr[go];
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = int'(rr[go]) + k;
        if (idx >= NP) idx -= NP;
        if (!hit && okgo[idx] && dest[idx] == 3'(go)) begin
          hit = 1'b1;
          w   = 3'(idx);
        end
      end
    end
    assign win[go]       = w;
    assign out_valid[go] = hit;
    assign out_data[go*DW +: DW] = {slot[w][DW-1:SB+1], nstamp[w], slot[w][SB-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
      for (int i = 0; i < NP; i++) rr[i] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (take[i]) full[i] <= 1'b0;
        if (in_valid[i] && in_ready[i]) full[i] <= 1'b1;
        if (out_valid[i] && out_ready[i]) rr[i] <= (win[i] == 3'd4) ? 3'd0 : win[i] + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (in_valid[i] && in_ready[i]) slot[i] <= in_data[i*DW +: DW];
  end
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW-1:0]   my_x,
  input logic [CW-1:0]   my_y,
  input logic [3:0]      nbr_alive,
  input logic [4:0]      in_valid,
  input logic [4:0]      in_ready,
  input logic [4:0]      out_valid,
  input logic [4:0]      out_ready,
  input logic [5*DW-1:0] out_data
);
  localparam int SB = DW - 1 - 2*CW;

  function automatic logic [CW-1:0] fx(input int p);
    return out_data[p*DW + DW-1 -: CW];
  endfunction
  function automatic logic [CW-1:0] fy(input int p);
    return out_data[p*DW + DW-1-CW -: CW];
  endfunction
  function automatic logic fs(input int p);
    return out_data[p*DW + SB];
  endfunction

  for (genvar d = 0; d < 4; d++) begin : g_mesh
    AST_NO_DEAD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[d] |-> nbr_alive[d]); // R8
    AST_MESH_NOT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[d] |-> !(fx(d) == my_x && fy(d) == my_y)); // R2
  end

  for (genvar i = 0; i < 5; i++) begin : g_slot
    AST_SLOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[i] && in_ready[i] |=> !in_ready[i]); // R10
  end

  AST_LOCAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[4] |-> (fx(4) == my_x && fy(4) == my_y && !fs(4))); // R2
  AST_PLAIN_NORTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] && !fs(0) |-> fy(0) > my_y); // R3
  AST_PLAIN_EAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] && !fs(1) |-> fx(1) > my_x); // R3
  AST_PLAIN_SOUTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[2] && !fs(2) |-> fy(2) < my_y); // R3
  AST_PLAIN_WEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[3] && !fs(3) |-> fx(3) < my_x); // R3
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[4] && !out_ready[4] && $stable(my_x) && $stable(my_y) |=> out_valid[4]); // R10
endmodule

bind mesh_router mesh_router_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/tb_mesh_router.sv
module tb_mesh_router;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   my_x, my_y;
  logic [3:0]   nbr_alive;
  logic [4:0]   in_valid, in_ready, out_valid, out_ready;
  logic [159:0] in_data, out_data;
  int n_chk = 0, n_err = 0;

  mesh_router dut (.clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .nbr_alive(nbr_alive),
                   .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
                   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] dx, input logic [3:0] dy, input logic st,
                                     input logic [22:0] pl);
    return {dx, dy, st, pl};
  endfunction

  // expected {port, stamp}; port 7 = packet must wait
  function automatic logic [3:0] model(input logic [31:0] p, input int src, input logic [3:0] al);
    logic [3:0] dx, dy; logic st; int port; logic so; int hx, vy, trav;
    dx = p[31:28]; dy = p[27:24]; st = p[23];
    hx = (dx > my_x) ? 1 : 3;
    vy = (dy > my_y) ? 0 : 2;
    port = -1; so = 1'b0;
    case (src)
      0: trav = 2; 1: trav = 3; 2: trav = 0; 3: trav = 1; default: trav = -1;
    endcase
    if (dx == my_x && dy == my_y) return {3'd4, 1'b0};
    if (st && trav >= 0) begin
      if ((trav == 0 || trav == 2) && dx != my_x) begin
        if (al[hx]) begin port = hx; so = 0; end else begin port = trav; so = 1; end
      end else if ((trav == 1 || trav == 3) && dy != my_y) begin
        if (al[vy]) begin port = vy; so = 0; end else begin port = trav; so = 1; end
      end
    end
    if (port < 0) begin
      if (dx != my_x) begin
        if (al[hx]) begin port = hx; so = 0; end
        else begin port = (dy >= my_y) ? 0 : 2; so = 1; end
      end else if (al[vy]) begin port = vy; so = 0; end
      else begin port = al[1] ? 1 : 3; so = 1; end
    end
    if (!al[port]) return {3'd7, 1'b0};
    return {3'(port), so};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = '0; out_ready = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int src, input logic [31:0] p);
    in_valid = '0;
    in_valid[src] = 1'b1;
    in_data[src*32 +: 32] = p;
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic expect_out(input int port, input logic [31:0] p, input logic so, input string req);
    logic [31:0] want;
    want = {p[31:24], so, p[22:0]};
    if (port == 7) begin
      check(out_valid == 5'd0, req, 64'(out_valid), 64'd0);
    end else begin
      check(out_valid == (5'b1 << port), req, 64'(out_valid), 64'(5'b1 << port));
      check(out_data[port*32 +: 32] == want, req, 64'(out_data[port*32 +: 32]), 64'(want));
    end
  endtask

  task automatic routed(input int src, input logic [31:0] p, input string req);
    logic [3:0] e;
    e = model(p, src, nbr_alive);
    send(src, p);
    expect_out(int'(e[3:1]), p, e[0], req);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] p;
    logic [3:0]  e;
    int r;
    in_data = '0; my_x = 4'd5; my_y = 4'd5; nbr_alive = 4'hF;
    do_reset();
    check(out_valid == 5'd0, "R1", 64'(out_valid), 64'd0);
    check(in_ready == 5'h1F, "R1", 64'(in_ready), 64'h1F);

    // R2 / R12: home delivery from a stamped mesh arrival
    p = mk(4'd5, 4'd5, 1'b1, 23'h5A5A5A);
    send(3, p); expect_out(4, p, 1'b0, "R2 R12 home"); @(negedge clk);

    // R3 plain XY
    p = mk(4'd9, 4'd2, 1'b0, 23'h000011); send(4, p); expect_out(1, p, 1'b0, "R3 east"); @(negedge clk);
    p = mk(4'd1, 4'd9, 1'b0, 23'h000012); send(4, p); expect_out(3, p, 1'b0, "R3 west first"); @(negedge clk);
    p = mk(4'd5, 4'd2, 1'b0, 23'h000013); send(4, p); expect_out(2, p, 1'b0, "R3 south"); @(negedge clk);

    // R4 horizontal blocked
    nbr_alive = 4'b0111;
    p = mk(4'd2, 4'd5, 1'b0, 23'h000021); send(4, p); expect_out(0, p, 1'b1, "R4 equal y north"); @(negedge clk);
    p = mk(4'd2, 4'd3, 1'b0, 23'h000022); send(4, p); expect_out(2, p, 1'b1, "R4 south"); @(negedge clk);

    // R5 vertical blocked
    nbr_alive = 4'b1011;
    p = mk(4'd5, 4'd1, 1'b0, 23'h000031); send(4, p); expect_out(1, p, 1'b1, "R5 east step"); @(negedge clk);
    nbr_alive = 4'b1001;
    p = mk(4'd5, 4'd1, 1'b0, 23'h000032); send(4, p); expect_out(3, p, 1'b1, "R5 west step"); @(negedge clk);

    // R6 stamped, travelling north (arrived on south port), destination behind
    nbr_alive = 4'b0111;
    p = mk(4'd2, 4'd1, 1'b1, 23'h000041); send(2, p); expect_out(0, p, 1'b1, "R6 keep north"); @(negedge clk);
    nbr_alive = 4'hF;
    p = mk(4'd2, 4'd1, 1'b1, 23'h000042); send(2, p); expect_out(3, p, 1'b0, "R6 corner clear"); @(negedge clk);

    // R7 stamped, travelling east (arrived on west port)
    nbr_alive = 4'b1011;
    p = mk(4'd1, 4'd1, 1'b1, 23'h000051); send(3, p); expect_out(1, p, 1'b1, "R7 keep east"); @(negedge clk);
    nbr_alive = 4'hF;
    p = mk(4'd1, 4'd1, 1'b1, 23'h000052); send(3, p); expect_out(2, p, 1'b0, "R7 corner clear"); @(negedge clk);

    // R9 stamp on local injection ignored
    nbr_alive = 4'b1101;
    p = mk(4'd9, 4'd5, 1'b1, 23'h000061); send(4, p); expect_out(0, p, 1'b1, "R9 local stamp"); @(negedge clk);

    // R8 wait for a route
    nbr_alive = 4'b1000;
    p = mk(4'd9, 4'd7, 1'b0, 23'h000071); send(4, p);
    expect_out(7, p, 1'b0, "R8 held");
    @(negedge clk);
    expect_out(7, p, 1'b0, "R8 still held");
    check(in_ready[4] == 1'b0, "R8 slot kept", 64'(in_ready), 64'h0F);
    nbr_alive = 4'b1001;
    #1;
    expect_out(0, p, 1'b1, "R8 released");
    @(negedge clk);
    check(out_valid == 5'd0 && in_ready == 5'h1F, "R8 drained", 64'({out_valid, in_ready}), 64'h1F);

    // R10 back-pressure
    nbr_alive = 4'hF; out_ready = 5'b11101;
    p = mk(4'd9, 4'd5, 1'b0, 23'h000081); send(4, p);
    repeat (3) begin
      expect_out(1, p, 1'b0, "R10 hold");
      check(in_ready[4] == 1'b0, "R10 busy", 64'(in_ready), 64'h0F);
      @(negedge clk);
    end
    out_ready = '1;
    @(negedge clk);
    check(out_valid == 5'd0 && in_ready == 5'h1F, "R10 release", 64'({out_valid, in_ready}), 64'h1F);

    // R11 round robin on east output
    do_reset();
    out_ready = 5'b11101;
    in_valid = 5'b11101;
    in_data[0*32 +: 32] = mk(4'd9, 4'd5, 1'b0, 23'd100);
    in_data[2*32 +: 32] = mk(4'd9, 4'd5, 1'b0, 23'd102);
    in_data[3*32 +: 32] = mk(4'd9, 4'd5, 1'b0, 23'd103);
    in_data[4*32 +: 32] = mk(4'd9, 4'd5, 1'b0, 23'd104);
    @(negedge clk);
    in_valid = '0;
    out_ready = '1;
    foreach (p[i]) begin end
    for (int k = 0; k < 4; k++) begin
      int want;
      want = (k == 0) ? 100 : (k == 1) ? 102 : (k == 2) ? 103 : 104;
      check(out_valid[1] && out_data[32 +: 23] == 23'(want), "R11 order",
            64'(out_data[32 +: 23]), 64'(want));
      @(negedge clk);
    end

    // random mix, all requirements on routing
    r = $urandom(32'd2024);
    for (int n = 0; n < 400; n++) begin
      int src;
      my_x = 4'($urandom_range(1, 14));
      my_y = 4'($urandom_range(1, 14));
      nbr_alive = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
      src = $urandom % 5;
      p = mk(($urandom % 4 == 0) ? my_x : 4'($urandom), ($urandom % 4 == 0) ? my_y : 4'($urandom),
             1'($urandom), 23'($urandom));
      e = model(p, src, nbr_alive);
      if (e[3:1] != 3'd7) routed(src, p, "R3 R4 R5 R6 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule